// File: doc/BRIEF.md
# ISDN Basic-Rate Channel Slot Multiplexer

This block carries the channels of up to ten ISDN basic-rate interfaces over one serial time-division-multiplexed line, one bit per clock. A frame has 256 bit positions: 32 slots of 8 bits each. Interface `i` uses three adjacent slots in a fixed order: slot `3i` for B1, slot `3i+1` for B2 and slot `3i+2` for D. Only the top two bits of a D slot carry signalling.

On the transmit side, the block takes one byte per channel from a flat parallel input. At the first bit of each slot it loads that slot's byte and shifts it out MSB first. Unassigned slots and slots that belong to inactive interfaces send all ones. On the receive side, the block samples the line at each bit position, rebuilds each slot byte, and writes it into that channel's byte of a flat output register bank. A one-cycle strobe marks each write.

A one-cycle frame-sync input marks bit 0 of slot 0 and realigns the free-running position counter. A count input sets how many interfaces are active.

Top module: `tdm_bri_mux`

## Requirements
- R1: While reset is held and just after it, `tx_line` is 1, `tx_load` and `rx_valid` are 0, and every byte of `rx_chan` is 0.
- R2: The position counter runs freely over 256 positions and wraps to 0. Once aligned by `fsync`, later frames keep their timing with `fsync` held low.
- R3: Channel `c` occupies slot `c` and byte `c` (bits `8c+7:8c`) of `tx_chan` and of `rx_chan`. Interface `i` owns channels `3i` (B1), `3i+1` (B2) and `3i+2` (D). The bit at frame position `8s+b` is bit `7-b` of slot `s`, so bits go out MSB first. It appears on `tx_line` in the cycle after the cycle in which the block is at that position.
- R4: In a transmitted D slot, bits 7:6 come from the channel byte and bits 5:0 are sent as 1.
- R5: Slots 30 and 31 send 8'hFF. So does every slot at or above `3*n_active`, with counts above 10 treated as 10.
- R6: `tx_load` pulses for one cycle with `tx_slot` equal to the slot number. The pulse comes in the same cycle as that slot's first bit on `tx_line`.
- R7: For an active B slot `s`, the eight bits on `rx_line` at that slot's positions are written, MSB first, into byte `s` of `rx_chan`. This happens in the cycle after the slot's eighth bit, and `rx_valid` is 1 with `rx_slot` = `s` for exactly that cycle.
- R8: A received D slot stores bits 7:6 from the line, and bits 5:0 are stored as 0.
- R9: Unassigned and inactive slots produce no `rx_valid` and leave every byte of `rx_chan` unchanged.
- R10: An `fsync` pulse at any position forces that cycle to be position 0. Transmit loading and receive capture restart from slot 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one frame bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | One-cycle marker of frame position 0 |
| rx_line | input | 1 | Received serial line |
| n_active | input | 4 | Number of active interfaces |
| tx_chan | input | 240 | Transmit byte per channel, channel c at bits 8c+7:8c |
| tx_line | output | 1 | Transmitted serial line |
| tx_load | output | 1 | Slot byte loaded strobe |
| tx_slot | output | 5 | Slot number of the byte just loaded |
| rx_valid | output | 1 | Received byte written strobe |
| rx_slot | output | 5 | Slot number of the byte just written |
| rx_chan | output | 240 | Received byte per channel, channel c at bits 8c+7:8c |

## Verification
The counter's own wrap to position 0 and an `fsync` pulse can arrive in the same cycle. Both then name slot 0, and the transmit load must happen exactly once, with no double strobe and no phase slip. The bench tests this by running aligned frames both with and without the pulse and comparing every slot byte and strobe against the same per-slot model. It also sends a pulse at position 100 of a running frame, where the pulse lands on a slot's fifth bit. After that pulse the next frame must decode and encode cleanly from slot 0.

// File: rtl/tdm_bri_mux.sv
module tdm_bri_mux #(
  parameter int MAX_IF    = 10,
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int D_LIVE    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              fsync,
  input  logic                              rx_line,
  input  logic [$clog2(MAX_IF+1)-1:0]       n_active,
  input  logic [3*MAX_IF*SLOT_BITS-1:0]     tx_chan,
  output logic                              tx_line,
  output logic                              tx_load,
  output logic [$clog2(SLOTS)-1:0]          tx_slot,
  output logic                              rx_valid,
  output logic [$clog2(SLOTS)-1:0]          rx_slot,
  output logic [3*MAX_IF*SLOT_BITS-1:0]     rx_chan
);
  localparam int W  = SLOT_BITS;
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int PW = SW + BW;
  localparam logic [W-1:0] KEEP = {{D_LIVE{1'b1}}, {(W-D_LIVE){1'b0}}};

  logic [PW-1:0] cnt, pos;
  logic [BW-1:0] bitn;
  logic [SW-1:0] slot;
  logic [W-1:0]  tx_sh, raw, tx_byte, rx_full, rx_store;
  logic [W-2:0]  rx_sh;
  logic          live, is_d;
  int            nact, idx;

  assign pos     = fsync ? '0 : cnt;
  assign bitn    = pos[BW-1:0];
  assign slot    = pos[PW-1:BW];
  assign rx_full = {rx_sh, rx_line};

  always_comb begin
    nact = int'(n_active);
    if (nact > MAX_IF) nact = MAX_IF;
    live = int'(slot) < 3 * nact;
    is_d = (int'(slot) % 3) == 2;
    idx  = live ? int'(slot) : 0;
    raw  = tx_chan[idx*W +: W];
  end

  assign tx_byte  = !live ? '1 : (is_d ? (raw | ~KEEP) : raw);
  assign rx_store = is_d ? (rx_full & KEEP) : rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tx_line  <= 1'b1;
      tx_sh    <= '1;
      tx_load  <= 1'b0;
      tx_slot  <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= '0;
      rx_chan  <= '0;
    end else begin
      cnt   <= pos + 1'b1;
      rx_sh <= rx_full[W-2:0];
      if (bitn == '0) begin
        tx_line <= tx_byte[W-1];
        tx_sh   <= {tx_byte[W-2:0], 1'b1};
        tx_load <= 1'b1;
        tx_slot <= slot;
      end else begin
        tx_line <= tx_sh[W-1];
        tx_sh   <= {tx_sh[W-2:0], 1'b1};
        tx_load <= 1'b0;
      end
      if (bitn == BW'(W-1) && live) begin
        rx_chan[idx*W +: W] <= rx_store;
        rx_valid            <= 1'b1;
        rx_slot             <= slot;
      end else begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_bri_mux_chk.sv
module tdm_bri_mux_chk #(
  parameter int MAX_IF    = 10,
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int D_LIVE    = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          fsync,
  input logic                          tx_line,
  input logic                          tx_load,
  input logic [$clog2(SLOTS)-1:0]      tx_slot,
  input logic                          rx_valid,
  input logic [$clog2(SLOTS)-1:0]      rx_slot,
  input logic [3*MAX_IF*SLOT_BITS-1:0] rx_chan
);
  localparam int NCH = 3 * MAX_IF;
  localparam int W   = SLOT_BITS;

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !fsync) |=> !tx_load);

  a_r10_fsync_load: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (tx_load && tx_slot == '0));

  a_r5_idle_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && int'(tx_slot) >= NCH) |-> tx_line);

  a_r9_rx_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> int'(rx_slot) < NCH);

  a_r8_dmask: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (int'(rx_slot) % 3) == 2) |-> rx_chan[int'(rx_slot)*W +: (W-D_LIVE)] == '0);
endmodule

bind tdm_bri_mux tdm_bri_mux_chk #(
  .MAX_IF(MAX_IF), .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .D_LIVE(D_LIVE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_line(tx_line),
  .tx_load(tx_load), .tx_slot(tx_slot), .rx_valid(rx_valid),
  .rx_slot(rx_slot), .rx_chan(rx_chan)
);

// File: tb/sim_tdm_bri_mux.sv
module sim_tdm_bri_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 30;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fsync = 1'b0;
  logic         rx_line = 1'b0;
  logic [3:0]   n_active = 4'd10;
  logic [239:0] tx_chan = '0;
  logic         tx_line, tx_load, rx_valid;
  logic [4:0]   tx_slot, rx_slot;
  logic [239:0] rx_chan;

  logic [239:0] exp_rx = '0;
  logic [7:0]   rxfr [32];
  int n_total = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_bri_mux u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_line(rx_line),
    .n_active(n_active), .tx_chan(tx_chan), .tx_line(tx_line),
    .tx_load(tx_load), .tx_slot(tx_slot), .rx_valid(rx_valid),
    .rx_slot(rx_slot), .rx_chan(rx_chan)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit live(input int s, input int n);
    int m = (n > 10) ? 10 : n;
    return s < 3 * m && s < NCH;
  endfunction

  function automatic logic [7:0] exp_tx(input int s, input int n);
    if (!live(s, n)) return 8'hFF;
    if (s % 3 == 2) return tx_chan[s*8 +: 8] | 8'h3F;
    return tx_chan[s*8 +: 8];
  endfunction

  task automatic run_frame(input bit use_fs, input int n, input int seed);
    logic [7:0] acc = '0;
    n_active = 4'(n);
    for (int c = 0; c < NCH; c++) tx_chan[c*8 +: 8] = 8'((c*29 + seed*71 + 5) ^ (c << 3));
    for (int s = 0; s < 32; s++) rxfr[s] = 8'((s*53 + seed*17 + 8'hA6) ^ (seed << s % 5));
    for (int p = 0; p < 256; p++) begin
      int s = p / 8;
      int b = p % 8;
      fsync   = use_fs && p == 0;
      rx_line = rxfr[s][7-b];
      @(negedge clk);
      acc[7-b] = tx_line;
      if (b == 0) chk(tx_load && tx_slot == 5'(s), "R6", "tx_load/slot at slot start", {tx_load, tx_slot}, {1'b1, 5'(s)});
      if (b == 4) chk(!tx_load, "R6", "tx_load mid-slot", tx_load, 0);
      if (b == 7) begin
        string t = !live(s, n) ? "R5" : (s % 3 == 2 ? "R4" : "R3");
        chk(acc == exp_tx(s, n), t, $sformatf("tx byte slot %0d", s), acc, exp_tx(s, n));
        chk(rx_valid == live(s, n), live(s, n) ? "R7" : "R9", $sformatf("rx_valid slot %0d", s), rx_valid, live(s, n));
        if (live(s, n)) begin
          logic [7:0] e = (s % 3 == 2) ? (rxfr[s] & 8'hC0) : rxfr[s];
          exp_rx[s*8 +: 8] = e;
          chk(rx_slot == 5'(s), "R7", "rx_slot", rx_slot, s);
          chk(rx_chan[s*8 +: 8] == e, (s % 3 == 2) ? "R8" : "R7", $sformatf("rx byte slot %0d", s), rx_chan[s*8 +: 8], e);
        end
      end
      if (b == 3) chk(!rx_valid, "R7", "rx_valid mid-slot", rx_valid, 0);
    end
    fsync = 1'b0;
    begin
      int bad = 0;
      for (int c = 0; c < NCH; c++) if (rx_chan[c*8 +: 8] !== exp_rx[c*8 +: 8]) bad++;
      chk(bad == 0, "R9", "rx register bytes differing from model", bad, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R1", "tx_line in reset", tx_line, 1);
    chk(!tx_load && !rx_valid, "R1", "strobes in reset", {tx_load, rx_valid}, 0);
    chk(rx_chan == '0, "R1", "rx_chan in reset", int'(rx_chan != '0), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_full();
    run_frame(1'b1, 10, 1);
  endtask

  task automatic t_free_run();
    int f0 = n_fail;
    run_frame(1'b0, 10, 2);
    chk(n_fail == f0, "R2", "free-running frame without fsync", n_fail - f0, 0);
  endtask

  task automatic t_partial_ifs();
    run_frame(1'b1, 4, 3);
    run_frame(1'b1, 1, 4);
  endtask

  task automatic t_realign();
    int f0;
    n_active = 4'd0;
    for (int i = 0; i < 100; i++) begin
      rx_line = i[0];
      @(negedge clk);
    end
    f0 = n_fail;
    run_frame(1'b1, 10, 5);
    chk(n_fail == f0, "R10", "frame after mid-frame fsync", n_fail - f0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_total++;
    n_fail++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full();
    t_free_run();
    t_partial_ifs();
    t_realign();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule